// File: doc/BRIEF.md
# Pin Control and Event Detect Unit

This block holds the configuration of one device pin in a single 32-bit register and watches that pin for events. Software writes the register through a plain one-word write port and reads it back on a read port. The register sets the pull resistor (on or off, up or down) and a 3-bit function select. It also holds a lock bit that freezes the lower half of the register until reset, a 4-bit event code and a sticky event flag. The pull and function-select fields drive the pad controls directly. The block only produces those control levels: the resistor itself and the routing of alternate functions are outside it.

The pin input passes through a two-flop synchronizer. One 4-bit code picks the trigger condition: rising edge, falling edge, either edge, low level or high level. The same code picks where a detected event goes, either to an interrupt line or to a DMA request line. The flag is cleared by writing a one to its bit. In DMA modes it is also cleared when the DMA-done input pulses. In level modes the flag sets again for as long as the pin stays at the active level.

Top module: `pad_cfg_top`

## Requirements
- R1: After a synchronous reset the register reads 0, and `irq_o`, `dma_req_o`, `pull_en_o`, `pull_up_o` and `mux_sel_o` are all 0.
- R2: While unlocked, a write stores pull select (bit 0), pull enable (bit 1), function select (bits 10:8) and lock (bit 15). Every bit that is not a field reads back 0. `mux_sel_o` equals bits 10:8.
- R3: `pull_en_o` is 1 only when pull enable is 1 and the function select is not 0 (0 means analog, 1 means GPIO, 2 to 7 are alternate functions). `pull_up_o` is `pull_en_o` AND pull select, where pull select 1 means pull-up and 0 means pull-down.
- R4: Once bit 15 is 1, writes leave bits 15:0 unchanged until the next reset, and software cannot clear the lock bit.
- R5: The event code in bits 19:16 takes every write, whether or not the register is locked.
- R6: Codes 1 and 9 set the flag on a rising edge, codes 2 and 10 on a falling edge, and codes 3 and 11 on either edge of the synchronized pin.
- R7: Code 8 sets the flag while the synchronized pin is 0, and code 12 while it is 1. While the pin holds the active level, a clear does not leave the flag at 0.
- R8: `irq_o` equals the flag while the code is 8 to 12. `dma_req_o` equals the flag while the code is 1 to 3. The two outputs are never 1 together.
- R9: A write with bit 24 set clears the flag. A write with bit 24 at 0 leaves the flag as it was. The flag holds its value when neither a clear nor an event occurs.
- R10: A `dma_done` pulse clears the flag only while the code is 1 to 3. Under any other code it has no effect.
- R11: Codes 0, 4 to 7 and 13 to 15 never set the flag.
- R12: Suppose the pin changes just before clock edge E0. The flag is still 0 after edge E1 and reads 1 after edge E2.
- R13: If an event and a write with bit 24 set fall in the same cycle, the flag ends that cycle set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Current register contents |
| pin_in | input | 1 | Asynchronous pin level |
| dma_done | input | 1 | One-cycle pulse marking the end of a DMA transfer |
| irq_o | output | 1 | Interrupt line |
| dma_req_o | output | 1 | DMA request line |
| pull_en_o | output | 1 | Pull resistor enable to the pad |
| pull_up_o | output | 1 | Pull direction, 1 = up |
| mux_sel_o | output | 3 | Function select to the pad |

## Verification
A write or a `dma_done` pulse is sampled at one clock edge. It shows on `rd_data` and on every output right after that edge, because the output flops load from the same next-state values as the register. A pin change reaches the flag two edges after the edge that first samples it. The bench models this with a queue of pin samples: it reads the synchronized level two entries back and the previous level three entries back, and it compares its model with every output one nanosecond after each rising edge. The directed checks for latency, clear priority and DMA completion count edges explicitly and sample only at the edge where the requirement says the result appears.

// File: rtl/pad_cfg_pkg.sv
package pad_cfg_pkg;

  localparam int REG_W     = 32;
  localparam int SEL_BIT   = 0;
  localparam int PEN_BIT   = 1;
  localparam int MUX_LSB   = 8;
  localparam int MUX_W     = 3;
  localparam int LOCK_BIT  = 15;
  localparam int CODE_LSB  = 16;
  localparam int CODE_W    = 4;
  localparam int FLAG_BIT  = 24;

  typedef enum logic [2:0] {
    TRIG_NONE,
    TRIG_RISE,
    TRIG_FALL,
    TRIG_BOTH,
    TRIG_LOW,
    TRIG_HIGH
  } trig_e;

  typedef struct packed {
    trig_e trig;
    logic  to_dma;
    logic  to_irq;
  } mode_t;

  typedef struct packed {
    logic [MUX_W-1:0] mux;
    logic             lock;
    logic             pull_en;
    logic             pull_sel;
  } pinctl_t;

  function automatic mode_t decode_mode(input logic [CODE_W-1:0] code);
    mode_t m;
    m = '{trig: TRIG_NONE, to_dma: 1'b0, to_irq: 1'b0};
    case (code)
      4'd1:  m = '{trig: TRIG_RISE, to_dma: 1'b1, to_irq: 1'b0};
      4'd2:  m = '{trig: TRIG_FALL, to_dma: 1'b1, to_irq: 1'b0};
      4'd3:  m = '{trig: TRIG_BOTH, to_dma: 1'b1, to_irq: 1'b0};
      4'd8:  m = '{trig: TRIG_LOW,  to_dma: 1'b0, to_irq: 1'b1};
      4'd9:  m = '{trig: TRIG_RISE, to_dma: 1'b0, to_irq: 1'b1};
      4'd10: m = '{trig: TRIG_FALL, to_dma: 1'b0, to_irq: 1'b1};
      4'd11: m = '{trig: TRIG_BOTH, to_dma: 1'b0, to_irq: 1'b1};
      4'd12: m = '{trig: TRIG_HIGH, to_dma: 1'b0, to_irq: 1'b1};
      default: ;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/pad_cfg_sync.sv
module pad_cfg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q,
  output logic q_prev
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) q_prev <= 1'b0;
    else     q_prev <= chain[STAGES-1];
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/pad_cfg_detect.sv
module pad_cfg_detect
  import pad_cfg_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic              cur,
  input  logic              prev,
  output logic              hit,
  output logic              dma_mode
);

  mode_t md;
  logic  rise, fall;

  always_comb begin
    md   = decode_mode(code);
    rise = cur & ~prev;
    fall = ~cur & prev;
    case (md.trig)
      TRIG_RISE: hit = rise;
      TRIG_FALL: hit = fall;
      TRIG_BOTH: hit = rise | fall;
      TRIG_LOW:  hit = ~cur;
      TRIG_HIGH: hit = cur;
      default:   hit = 1'b0;
    endcase
    dma_mode = md.to_dma;
  end

endmodule

// File: rtl/pad_cfg_regfile.sv
module pad_cfg_regfile
  import pad_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  pinctl_t           wr_ctl,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              wr_clr,
  input  logic              hit,
  input  logic              dma_done,
  input  logic              dma_mode,
  output pinctl_t           ctl_q,
  output pinctl_t           ctl_d,
  output logic [CODE_W-1:0] code_q,
  output logic [CODE_W-1:0] code_d,
  output logic              flag_q,
  output logic              flag_d
);

  logic clr;

  always_comb begin
    ctl_d  = ctl_q;
    code_d = code_q;
    if (wr_en) begin
      code_d = wr_code;
      if (!ctl_q.lock) ctl_d = wr_ctl;
    end
    clr    = (wr_en & wr_clr) | (dma_done & dma_mode);
    // a new event wins over any clear in the same cycle
    flag_d = hit | (flag_q & ~clr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= '0;
      code_q <= '0;
      flag_q <= 1'b0;
    end else begin
      ctl_q  <= ctl_d;
      code_q <= code_d;
      flag_q <= flag_d;
    end
  end

endmodule

// File: rtl/pad_cfg_top.sv
module pad_cfg_top
  import pad_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             pin_in,
  input  logic             dma_done,
  output logic             irq_o,
  output logic             dma_req_o,
  output logic             pull_en_o,
  output logic             pull_up_o,
  output logic [MUX_W-1:0] mux_sel_o
);

  logic              pin_s, pin_p, hit, dma_mode;
  pinctl_t           wr_ctl, ctl_q, ctl_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              flag_q, flag_d;
  mode_t             md_next;
  logic              wr_unused_bits;

  assign wr_ctl = '{mux:      wr_data[MUX_LSB +: MUX_W],
                    lock:     wr_data[LOCK_BIT],
                    pull_en:  wr_data[PEN_BIT],
                    pull_sel: wr_data[SEL_BIT]};
  assign wr_unused_bits = ^{wr_data[REG_W-1:FLAG_BIT+1], wr_data[FLAG_BIT-1:CODE_LSB+CODE_W],
                            wr_data[LOCK_BIT-1:MUX_LSB+MUX_W], wr_data[MUX_LSB-1:PEN_BIT+1]};

  pad_cfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pin_s), .q_prev(pin_p)
  );

  pad_cfg_detect u_det (
    .code(code_q), .cur(pin_s), .prev(pin_p), .hit(hit), .dma_mode(dma_mode)
  );

  pad_cfg_regfile u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ctl(wr_ctl),
    .wr_code(wr_data[CODE_LSB +: CODE_W]), .wr_clr(wr_data[FLAG_BIT]),
    .hit(hit), .dma_done(dma_done), .dma_mode(dma_mode),
    .ctl_q(ctl_q), .ctl_d(ctl_d), .code_q(code_q), .code_d(code_d),
    .flag_q(flag_q), .flag_d(flag_d)
  );

  // outputs load from next-state values so they line up with the register
  assign md_next = decode_mode(code_d);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o     <= 1'b0;
      dma_req_o <= 1'b0;
      pull_en_o <= 1'b0;
      pull_up_o <= 1'b0;
      mux_sel_o <= '0;
    end else begin
      irq_o     <= flag_d & md_next.to_irq;
      dma_req_o <= flag_d & md_next.to_dma;
      pull_en_o <= ctl_d.pull_en & (ctl_d.mux != '0);
      pull_up_o <= ctl_d.pull_en & (ctl_d.mux != '0) & ctl_d.pull_sel;
      mux_sel_o <= ctl_d.mux;
    end
  end

  always_comb begin
    rd_data                        = '0;
    rd_data[SEL_BIT]               = ctl_q.pull_sel;
    rd_data[PEN_BIT]               = ctl_q.pull_en;
    rd_data[MUX_LSB +: MUX_W]      = ctl_q.mux;
    rd_data[LOCK_BIT]              = ctl_q.lock;
    rd_data[CODE_LSB +: CODE_W]    = code_q;
    rd_data[FLAG_BIT]              = flag_q;
  end

endmodule

// File: rtl/pad_cfg_checker.sv
module pad_cfg_checker
  import pad_cfg_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              clr_req,
  input logic              dma_done,
  input logic              flag,
  input logic [CODE_W-1:0] code,
  input logic [15:0]       low_half,
  input logic              irq_o,
  input logic              dma_req_o,
  input logic              pull_en_o,
  input logic [MUX_W-1:0]  mux_sel_o
);

  p_lock_holds_r4: assert property (@(posedge clk) disable iff (rst)
    low_half[LOCK_BIT] |=> low_half[LOCK_BIT]);

  p_locked_frozen_r4: assert property (@(posedge clk) disable iff (rst)
    low_half[LOCK_BIT] |=> $stable(low_half));

  p_pull_digital_r3: assert property (@(posedge clk) disable iff (rst)
    pull_en_o |-> (mux_sel_o != '0));

  p_one_output_r8: assert property (@(posedge clk) disable iff (rst)
    !(irq_o && dma_req_o));

  p_output_has_flag_r8: assert property (@(posedge clk) disable iff (rst)
    (irq_o || dma_req_o) |-> flag);

  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr_req && !dma_done) |=> flag);

  p_reserved_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (decode_mode(code).trig == TRIG_NONE) |=> !$rose(flag));

endmodule

bind pad_cfg_top pad_cfg_checker u_chk (
  .clk(clk), .rst(rst),
  .clr_req(wr_en & wr_data[24]), .dma_done(dma_done),
  .flag(rd_data[24]), .code(rd_data[19:16]), .low_half(rd_data[15:0]),
  .irq_o(irq_o), .dma_req_o(dma_req_o), .pull_en_o(pull_en_o), .mux_sel_o(mux_sel_o)
);

// File: tb/pad_cfg_top_tb.sv
`timescale 1ns/1ps
module pad_cfg_top_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        pin_in = 1'b0;
  logic        dma_done = 1'b0;
  logic        irq_o, dma_req_o, pull_en_o, pull_up_o;
  logic [2:0]  mux_sel_o;

  int checks = 0;
  int errors = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pad_cfg_top u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .pin_in(pin_in), .dma_done(dma_done), .irq_o(irq_o), .dma_req_o(dma_req_o),
    .pull_en_o(pull_en_o), .pull_up_o(pull_up_o), .mux_sel_o(mux_sel_o)
  );

  // behavioural reference state
  bit       m_ps, m_pe, m_lk, m_flag;
  bit [2:0] m_mux;
  bit [3:0] m_code;
  bit       pin_q[$];

  function automatic int kind(input bit [3:0] c); // 0 none, 1 dma edge, 2 irq edge, 3 irq level
    if (c >= 1 && c <= 3) return 1;
    if (c >= 9 && c <= 11) return 2;
    if (c == 8 || c == 12) return 3;
    return 0;
  endfunction

  function automatic bit event_of(input bit [3:0] c, input bit cur, input bit old);
    int e;
    e = (c == 1 || c == 9) ? 1 : (c == 2 || c == 10) ? 2 : (c == 3 || c == 11) ? 3 : 0;
    if (c == 8)  return !cur;
    if (c == 12) return cur;
    if (e == 1)  return cur && !old;
    if (e == 2)  return !cur && old;
    if (e == 3)  return cur != old;
    return 1'b0;
  endfunction

  function automatic bit [31:0] m_word();
    bit [31:0] w;
    w = '0;
    w[0] = m_ps; w[1] = m_pe; w[10:8] = m_mux; w[15] = m_lk;
    w[19:16] = m_code; w[24] = m_flag;
    return w;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_ps = 0; m_pe = 0; m_lk = 0; m_flag = 0; m_mux = 0; m_code = 0;
      pin_q = '{1'b0, 1'b0, 1'b0};
    end else begin
      bit ev, clr;
      ev  = event_of(m_code, pin_q[$-1], pin_q[$-2]);
      clr = (wr_en && wr_data[24]) || (dma_done && kind(m_code) == 1);
      if (ev) m_flag = 1;
      else if (clr) m_flag = 0;
      if (wr_en) begin
        m_code = wr_data[19:16];
        if (!m_lk) begin
          m_ps = wr_data[0]; m_pe = wr_data[1]; m_mux = wr_data[10:8]; m_lk = wr_data[15];
        end
      end
      pin_q.push_back(pin_in);
      if (pin_q.size() > 8) void'(pin_q.pop_front());
    end
    #1;
    if (cmp_on && !rst) begin
      string ftag;
      ftag = (kind(m_code) == 3) ? "R7 level flag" : (kind(m_code) == 0) ? "R11 idle flag" : "R6 edge flag";
      chk("R2 fields", {21'b0, rd_data[10:0]}, {21'b0, m_word() & 32'h0000_0703});
      chk("R2 mux_sel_o", 32'(mux_sel_o), 32'(m_mux));
      chk("R2 reserved bits", rd_data & 32'hFEF0_78FC, 32'h0);
      chk("R3 pull_en_o", 32'(pull_en_o), 32'(m_pe && m_mux != 0));
      chk("R3 pull_up_o", 32'(pull_up_o), 32'(m_pe && m_mux != 0 && m_ps));
      chk("R4 lock bit", 32'(rd_data[15]), 32'(m_lk));
      chk("R5 code field", 32'(rd_data[19:16]), 32'(m_code));
      chk(ftag, 32'(rd_data[24]), 32'(m_flag));
      chk("R8 irq_o", 32'(irq_o), 32'(m_flag && kind(m_code) >= 2));
      chk("R8 dma_req_o", 32'(dma_req_o), 32'(m_flag && kind(m_code) == 1));
    end
  end

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pin_to(input logic v);
    @(negedge clk); pin_in = v;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_done();
    @(negedge clk); dma_done = 1'b1;
    @(negedge clk); dma_done = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; pin_in = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    do_reset();
    chk("R1 reset rd_data", rd_data, 32'h0);
    chk("R1 reset outputs", {27'b0, irq_o, dma_req_o, pull_en_o, pull_up_o, 1'b0},
        32'h0);
    chk("R1 reset mux", 32'(mux_sel_o), 32'h0);
    cmp_on = 1'b1;

    // pulls: digital pin with pull-up, then analog pin
    wr(32'h0000_0103);
    chk("R3 pull-up on GPIO", {30'b0, pull_en_o, pull_up_o}, 32'h3);
    wr(32'h0000_0003);
    chk("R3 no pull in analog", {30'b0, pull_en_o, pull_up_o}, 32'h0);

    // rising edge interrupt and latency
    wr(32'h0009_0100);
    pin_to(1'b1);
    @(posedge clk); @(posedge clk); #1;
    chk("R12 flag not yet after E1", 32'(rd_data[24]), 32'h0);
    @(posedge clk); #1;
    chk("R12 flag set after E2", 32'(rd_data[24]), 32'h1);
    wr(32'h0009_0100);
    chk("R9 write zero keeps flag", 32'(rd_data[24]), 32'h1);
    wr(32'h0109_0100);
    chk("R9 write one clears flag", 32'(rd_data[24]), 32'h0);

    // low level interrupt holds through a clear
    wr(32'h0008_0100);
    pin_to(1'b0);
    edges(3);
    chk("R7 low level irq", 32'(irq_o), 32'h1);
    wr(32'h0108_0100);
    chk("R7 clear while held low", 32'(rd_data[24]), 32'h1);
    pin_to(1'b1);
    edges(4);
    wr(32'h0108_0100);
    chk("R7 clear after release", 32'(rd_data[24]), 32'h0);

    // DMA on rising edge, cleared by completion
    wr(32'h0001_0100);
    pin_to(1'b0); edges(3);
    chk("R6 falling ignored by rising code", 32'(rd_data[24]), 32'h0);
    pin_to(1'b1); edges(3);
    chk("R8 dma request", {30'b0, dma_req_o, irq_o}, 32'h2);
    pulse_done();
    chk("R10 done clears in DMA mode", 32'(rd_data[24]), 32'h0);

    // either edge interrupt, completion has no effect
    wr(32'h000B_0100);
    pin_to(1'b0); edges(3);
    chk("R6 either edge irq", 32'(irq_o), 32'h1);
    pulse_done();
    chk("R10 done ignored in irq mode", 32'(rd_data[24]), 32'h1);
    wr(32'h010B_0100);

    // reserved code
    wr(32'h0005_0100);
    pin_to(1'b1); edges(3);
    pin_to(1'b0); edges(3);
    pin_to(1'b1); edges(3);
    chk("R11 reserved code quiet", 32'(rd_data[24]), 32'h0);

    // event and clear in the same cycle
    wr(32'h0009_0100);
    pin_to(1'b0); edges(3);
    pin_to(1'b1);
    @(negedge clk);
    @(negedge clk); wr_en = 1'b1; wr_data = 32'h0109_0100;
    @(posedge clk); #1;
    chk("R13 event beats clear", 32'(rd_data[24]), 32'h1);
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
    wr(32'h0109_0100);

    // mixed traffic, unlocked
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      pin_in   = 1'($urandom);
      dma_done = (($urandom % 8) == 0);
      wr_en    = (($urandom % 6) == 0);
      wr_data  = $urandom & 32'h01FF_7F03;
    end
    @(negedge clk); wr_en = 1'b0; dma_done = 1'b0; wr_data = '0;

    // lock
    wr(32'h0100_8103);
    wr(32'h0000_0205);
    chk("R4 locked lower half", 32'(rd_data[15:0]), 32'h8103);
    chk("R5 code writable when locked", 32'(rd_data[19:16]), 32'h0);
    wr(32'h000C_0000);
    chk("R4 lock not clearable", 32'(rd_data[15:0]), 32'h8103);
    chk("R5 code 12 stored when locked", 32'(rd_data[19:16]), 32'hC);

    // reset releases the lock
    cmp_on = 1'b0;
    do_reset();
    chk("R1 reset clears lock", rd_data, 32'h0);
    cmp_on = 1'b1;
    wr(32'h0000_0200);
    chk("R4 unlocked after reset", 32'(mux_sel_o), 32'h2);

    edges(2);
    finish_run();
  end

endmodule